// File: doc/BRIEF.md
# Transmit Descriptor Chain Reader

This block walks a chain of transmit descriptors held in a small word-addressed descriptor memory and hands each buffer it finds to a payload mover. Each descriptor is two words: the word at an even offset from the chain start holds the buffer address, and the next word holds the status. Software writes the chain into memory and presents its start address on `queueBase`. It then writes the control word with both the transmitter-enable bit and the start bit set. The block latches the base, reads the descriptors in order, and for every descriptor that is not yet marked used it issues a one-cycle buffer strobe carrying the address, the byte length and the last-buffer flag.

A descriptor whose used bit is already set ends the walk. When a buffer flagged as the end of a frame has gone out, the block writes the status word of that frame's first descriptor back with the used bit set. Then it continues with the next descriptor. If the chain runs into a used descriptor in the middle of a frame, the first descriptor is written back with the used bit and an exhausted flag, and the walk stops. When the walk stops, a sticky done bit is set in the transmit status word. Software clears it by writing a 1 to that bit.

Top module: `tx_desc_reader`

## Requirements
- R1: After reset, `busy`, `bufValid`, `memRdEn` and `memWrEn` are 0 and `txStat` is 0.
- R2: A control write (`ctrlWrEn`) with bit 9 (start) and bit 3 (transmit enable) of `ctrlWrData` both set, made while idle, raises `busy` on the next cycle and begins the walk at `queueBase`. A start write with bit 3 clear is ignored.
- R3: A start write made while `busy` is high is ignored: buffers already sent are not sent again, and the walk is not restarted.
- R4: Descriptor i lies at word `base+2i` (buffer address) and word `base+2i+1` (status). For each descriptor whose status bit 31 is clear, one `bufValid` pulse is issued, in chain order. `bufAddr` is the address word, `bufLen` is status bits 10:0 and `bufLast` is status bit 15.
- R5: After a descriptor with status bit 30 (wrap) set, the next descriptor is fetched at the latched base. Otherwise it is fetched two words further on.
- R6: A descriptor with status bit 31 set, met at a frame boundary, ends the walk. No buffer is issued, no memory write is made, `busy` falls and `txStat` bit 5 (done) is set.
- R7: After a buffer with bit 15 set has been issued, the status word of that frame's first descriptor is written back once, with bit 31 set and all other bits unchanged. The walk then continues.
- R8: A used descriptor met after a buffer without bit 15 writes the frame's first status back with bits 31 and 27 set, keeps its other bits, and ends the walk with done set.
- R9: Done stays set until a status write (`statWrEn`) with bit 5 of `statWrData` set clears it. A status write with bit 5 clear has no effect.
- R10: The start bit acts once: after a walk ends, the block stays idle and issues no further buffers until a new start write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 32 | Control word (bit 9 start, bit 3 enable) |
| statWrEn | input | 1 | Status word write strobe |
| statWrData | input | 32 | Write-1-to-clear mask for status bits |
| queueBase | input | ADDR_W | Word address of the first descriptor |
| txStat | output | 32 | Transmit status word (bit 5 done) |
| busy | output | 1 | Walk in progress |
| memRdEn | output | 1 | Descriptor memory read enable |
| memRdAddr | output | ADDR_W | Descriptor memory read address |
| memRdData | input | 32 | Read data, valid the cycle after `memRdEn` |
| memWrEn | output | 1 | Descriptor memory write enable |
| memWrAddr | output | ADDR_W | Descriptor memory write address |
| memWrData | output | 32 | Descriptor memory write data |
| bufValid | output | 1 | One-cycle buffer strobe to the payload mover |
| bufAddr | output | 32 | Buffer address |
| bufLen | output | 11 | Buffer length in bytes |
| bufLast | output | 1 | Buffer ends a frame |

## Verification
Most wrong internal states show up at the ports within one descriptor fetch, which takes three to four cycles. A wrong chain pointer sends a buffer with the wrong address or a duplicate. A lost in-frame flag makes a mid-chain used descriptor end the walk quietly, with no exhausted write-back. A wrong first-descriptor register puts the write-back at the wrong word, and the bench sees this when it reads memory after the walk. The bench compares every buffer strobe, every memory write and the done bit against values worked out from the descriptor contents. It checks the wrap, the frame boundaries and the repeated start requests directly.

// File: rtl/tx_desc_pkg.sv
package tx_desc_pkg;
  localparam int USED_BIT  = 31;
  localparam int WRAP_BIT  = 30;
  localparam int EXH_BIT   = 27;
  localparam int LAST_BIT  = 15;
  localparam int LEN_W     = 11;
  localparam int START_BIT = 9;
  localparam int EN_BIT    = 3;
  localparam int DONE_BIT  = 5;

  typedef struct packed {
    logic loadBase;
    logic rdStat;
    logic captStat;
    logic markFirst;
    logic setExh;
    logic rdAddr;
    logic emit;
    logic writeBack;
    logic setDone;
  } ctlStrobes_t;
endpackage

// File: rtl/tx_desc_ctl.sv
module tx_desc_ctl
  import tx_desc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startReq,
  input  logic        usedBit,
  input  logic        lastBit,
  input  logic        inFrame,
  input  logic        exhFlag,
  output ctlStrobes_t stb,
  output logic        busy
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT_RD, ST_STAT_CHK, ST_ADDR_RD, ST_EMIT, ST_WBACK
  } state_t;

  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startReq) begin
        stb.loadBase = 1'b1;
        stateNext    = ST_STAT_RD;
      end
      ST_STAT_RD: begin
        stb.rdStat = 1'b1;
        stateNext  = ST_STAT_CHK;
      end
      ST_STAT_CHK: begin
        stb.captStat = 1'b1;
        if (usedBit && inFrame) begin
          stb.setExh = 1'b1;
          stateNext  = ST_WBACK;
        end else if (usedBit) begin
          stb.setDone = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          stb.markFirst = !inFrame;
          stateNext     = ST_ADDR_RD;
        end
      end
      ST_ADDR_RD: begin
        stb.rdAddr = 1'b1;
        stateNext  = ST_EMIT;
      end
      ST_EMIT: begin
        stb.emit  = 1'b1;
        stateNext = lastBit ? ST_WBACK : ST_STAT_RD;
      end
      ST_WBACK: begin
        stb.writeBack = 1'b1;
        stb.setDone   = exhFlag;
        stateNext     = exhFlag ? ST_IDLE : ST_STAT_RD;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/tx_desc_dp.sv
module tx_desc_dp
  import tx_desc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       stb,
  input  logic [ADDR_W-1:0] queueBase,
  input  logic              doneClr,
  input  logic [31:0]       memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic              bufValid,
  output logic [31:0]       bufAddr,
  output logic [LEN_W-1:0]  bufLen,
  output logic              bufLast,
  output logic              usedBit,
  output logic              lastBit,
  output logic              inFrame,
  output logic              exhFlag,
  output logic              doneBit
);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] baseReg, ptr, firstPtr;
  logic [31:0]       firstStat;
  logic [LEN_W-1:0]  curLen;
  logic              curLast, curWrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseReg   <= '0;
      ptr       <= '0;
      firstPtr  <= '0;
      firstStat <= '0;
      curLen    <= '0;
      curLast   <= 1'b0;
      curWrap   <= 1'b0;
      inFrame   <= 1'b0;
      exhFlag   <= 1'b0;
      doneBit   <= 1'b0;
    end else begin
      if (stb.loadBase) begin
        baseReg <= queueBase;
        ptr     <= queueBase;
        inFrame <= 1'b0;
        exhFlag <= 1'b0;
      end
      if (stb.captStat) begin
        curLen  <= memRdData[LEN_W-1:0];
        curLast <= memRdData[LAST_BIT];
        curWrap <= memRdData[WRAP_BIT];
      end
      if (stb.markFirst) begin
        firstPtr  <= ptr;
        firstStat <= memRdData;
      end
      if (stb.setExh) exhFlag <= 1'b1;
      if (stb.emit) begin
        ptr     <= curWrap ? baseReg : ptr + DESC_STEP;
        inFrame <= !curLast;
      end
      if (stb.writeBack) begin
        inFrame <= 1'b0;
        exhFlag <= 1'b0;
      end
      if (stb.setDone)    doneBit <= 1'b1;
      else if (doneClr)   doneBit <= 1'b0;
    end
  end

  assign memRdEn   = stb.rdStat | stb.rdAddr;
  assign memRdAddr = stb.rdStat ? ptr + STAT_OFS : ptr;

  assign memWrEn   = stb.writeBack;
  assign memWrAddr = firstPtr + STAT_OFS;
  always_comb begin
    memWrData           = firstStat;
    memWrData[USED_BIT] = 1'b1;
    if (exhFlag) memWrData[EXH_BIT] = 1'b1;
  end

  assign bufValid = stb.emit;
  assign bufAddr  = memRdData;
  assign bufLen   = curLen;
  assign bufLast  = curLast;

  assign usedBit = memRdData[USED_BIT];
  assign lastBit = curLast;
endmodule

// File: rtl/tx_desc_reader.sv
module tx_desc_reader
  import tx_desc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrlWrEn,
  input  logic [31:0]       ctrlWrData,
  input  logic              statWrEn,
  input  logic [31:0]       statWrData,
  input  logic [ADDR_W-1:0] queueBase,
  output logic [31:0]       txStat,
  output logic              busy,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [31:0]       memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic              bufValid,
  output logic [31:0]       bufAddr,
  output logic [10:0]       bufLen,
  output logic              bufLast
);
  ctlStrobes_t stb;
  logic startReq, doneClr, usedBit, lastBit, inFrame, exhFlag, doneBit;
  logic unusedWrBits;

  assign startReq = ctrlWrEn && ctrlWrData[START_BIT] && ctrlWrData[EN_BIT];
  assign doneClr  = statWrEn && statWrData[DONE_BIT];
  assign unusedWrBits = ^{ctrlWrData[31:10], ctrlWrData[8:4], ctrlWrData[2:0],
                          statWrData[31:6], statWrData[4:0]};

  tx_desc_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .usedBit(usedBit),
    .lastBit(lastBit), .inFrame(inFrame), .exhFlag(exhFlag),
    .stb(stb), .busy(busy)
  );

  tx_desc_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .queueBase(queueBase),
    .doneClr(doneClr), .memRdData(memRdData), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .bufValid(bufValid), .bufAddr(bufAddr),
    .bufLen(bufLen), .bufLast(bufLast), .usedBit(usedBit),
    .lastBit(lastBit), .inFrame(inFrame), .exhFlag(exhFlag),
    .doneBit(doneBit)
  );

  always_comb begin
    txStat           = '0;
    txStat[DONE_BIT] = doneBit;
  end
endmodule

// File: rtl/tx_desc_reader_chk.sv
module tx_desc_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrlWrEn,
  input logic [31:0] ctrlWrData,
  input logic        statWrEn,
  input logic [31:0] statWrData,
  input logic [31:0] txStat,
  input logic        busy,
  input logic        memRdEn,
  input logic        memWrEn,
  input logic [31:0] memWrData,
  input logic        bufValid
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && txStat == 32'h0));

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrlWrEn && ctrlWrData[9] && ctrlWrData[3]));

  assert_emit_in_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bufValid |-> busy);

  assert_walk_end_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> txStat[5]);

  assert_wback_used_R7: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn |-> memWrData[31]);

  assert_mem_port_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(memWrEn && memRdEn));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txStat[5] && !(statWrEn && statWrData[5])) |=> txStat[5]);

  assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && statWrEn && statWrData[5]) |=> !txStat[5]);
endmodule

bind tx_desc_reader tx_desc_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
  .statWrEn(statWrEn), .statWrData(statWrData), .txStat(txStat),
  .busy(busy), .memRdEn(memRdEn), .memWrEn(memWrEn),
  .memWrData(memWrData), .bufValid(bufValid)
);

// File: tb/tx_desc_reader_test.sv
module tx_desc_reader_test;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrlWrEn = 1'b0, statWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0, statWrData = '0;
  logic [AW-1:0] queueBase = '0;
  logic [31:0] txStat, memRdData, memWrData, bufAddr;
  logic busy, memRdEn, memWrEn, bufValid, bufLast;
  logic [AW-1:0] memRdAddr, memWrAddr;
  logic [10:0] bufLen;

  logic [31:0] mem [0:255];
  int errors = 0, checks = 0;
  int emitCnt = 0, wrCnt = 0;
  logic [31:0] emAddr [0:15];
  logic [10:0] emLen [0:15];
  logic        emLast [0:15];

  always #2 clk = ~clk;

  tx_desc_reader #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .statWrEn(statWrEn), .statWrData(statWrData), .queueBase(queueBase),
    .txStat(txStat), .busy(busy), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .bufValid(bufValid), .bufAddr(bufAddr),
    .bufLen(bufLen), .bufLast(bufLast)
  );

  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memRdAddr];
    if (memWrEn) mem[memWrAddr] <= memWrData;
  end

  always @(negedge clk) begin
    if (bufValid) begin
      if (emitCnt < 16) begin
        emAddr[emitCnt] = bufAddr;
        emLen[emitCnt]  = bufLen;
        emLast[emitCnt] = bufLast;
      end
      emitCnt++;
    end
    if (memWrEn) wrCnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    emitCnt = 0;
    wrCnt = 0;
  endtask

  task automatic startWalk(input logic [AW-1:0] base, input logic [31:0] ctl);
    @(negedge clk);
    queueBase  = base;
    ctrlWrEn   = 1'b1;
    ctrlWrData = ctl;
    @(negedge clk);
    ctrlWrEn   = 1'b0;
    ctrlWrData = '0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic clearDone();
    @(negedge clk);
    statWrEn = 1'b1;
    statWrData = 32'h20;
    @(negedge clk);
    statWrEn = 1'b0;
    statWrData = '0;
  endtask

  task automatic testReset();
    chk("R1 busy", {31'h0, busy}, 32'h0);
    chk("R1 txStat", txStat, 32'h0);
    chk("R1 memRdEn/memWrEn/bufValid", {29'h0, memRdEn, memWrEn, bufValid}, 32'h0);
  endtask

  task automatic testSingle();
    clearMem();
    mem[0] = 32'h0000_1000; mem[1] = 32'h0000_803C;
    mem[3] = 32'h8000_0000;
    startWalk(8'd0, 32'h208);
    chk("R2 busy after start", {31'h0, busy}, 32'h1);
    waitIdle();
    chk("R4 single emit count", emitCnt, 1);
    chk("R4 single addr", emAddr[0], 32'h1000);
    chk("R4 single len", {21'h0, emLen[0]}, 32'd60);
    chk("R4 single last", {31'h0, emLast[0]}, 32'h1);
    chk("R7 single writeback", mem[1], 32'h8000_803C);
    chk("R6 done after walk", txStat, 32'h20);
    repeat (30) @(negedge clk);
    chk("R10 stays idle", {31'h0, busy}, 32'h0);
    chk("R10 no extra emits", emitCnt, 1);
  endtask

  task automatic testMulti(input bit restart);
    clearMem();
    mem[16] = 32'h100; mem[17] = 32'h0010_0064;
    mem[18] = 32'h200; mem[19] = 32'h0000_80C8;
    mem[20] = 32'h300; mem[21] = 32'h0000_812C;
    mem[23] = 32'h8000_0000;
    startWalk(8'd16, 32'h208);
    if (restart) begin
      repeat (5) @(negedge clk);
      startWalk(8'd16, 32'h208);
      repeat (3) @(negedge clk);
      startWalk(8'd16, 32'h208);
    end
    waitIdle();
    if (restart) begin
      chk("R3 emits with restarts", emitCnt, 3);
      chk("R3 writebacks with restarts", wrCnt, 2);
    end else begin
      chk("R4 multi emit count", emitCnt, 3);
      chk("R4 multi addr0", emAddr[0], 32'h100);
      chk("R4 multi last0", {31'h0, emLast[0]}, 32'h0);
      chk("R4 multi len1", {21'h0, emLen[1]}, 32'd200);
      chk("R4 multi addr2", emAddr[2], 32'h300);
      chk("R7 frame A first wb", mem[17], 32'h8010_0064);
      chk("R7 frame A second untouched", mem[19], 32'h0000_80C8);
      chk("R7 frame B wb", mem[21], 32'h8000_812C);
      chk("R7 write count", wrCnt, 2);
    end
  endtask

  task automatic testWrap();
    clearMem();
    mem[32] = 32'hA00; mem[33] = 32'h0000_8040;
    mem[34] = 32'hB00; mem[35] = 32'h4000_8080;
    mem[36] = 32'hD00; mem[37] = 32'h0000_8005;
    startWalk(8'd32, 32'h208);
    waitIdle();
    chk("R5 wrap emit count", emitCnt, 2);
    chk("R5 wrap second addr", emAddr[1], 32'hB00);
    chk("R5 wrap wb d1", mem[35], 32'hC000_8080);
    chk("R6 stop at revisited used", txStat, 32'h20);
  endtask

  task automatic testExhaust();
    clearMem();
    mem[40] = 32'hC00; mem[41] = 32'h0000_0014;
    mem[43] = 32'h8000_0000;
    startWalk(8'd40, 32'h208);
    waitIdle();
    chk("R8 exhaust emit count", emitCnt, 1);
    chk("R8 exhaust last flag", {31'h0, emLast[0]}, 32'h0);
    chk("R8 exhaust writeback", mem[41], 32'h8800_0014);
    chk("R8 done", txStat, 32'h20);
  endtask

  task automatic testEmpty();
    clearMem();
    mem[48] = 32'hE00; mem[49] = 32'h8000_8010;
    startWalk(8'd48, 32'h208);
    waitIdle();
    chk("R6 empty no emits", emitCnt, 0);
    chk("R6 empty no writes", wrCnt, 0);
    chk("R6 empty done", txStat, 32'h20);
    chk("R6 empty idle", {31'h0, busy}, 32'h0);
  endtask

  task automatic testEnableOff();
    clearMem();
    mem[0] = 32'h1000; mem[1] = 32'h0000_803C;
    mem[3] = 32'h8000_0000;
    startWalk(8'd0, 32'h200);
    repeat (20) @(negedge clk);
    chk("R2 no start without enable", {31'h0, busy}, 32'h0);
    chk("R2 no emits without enable", emitCnt, 0);
  endtask

  task automatic testW1C();
    chk("R9 done set before clear", txStat, 32'h20);
    @(negedge clk);
    statWrEn = 1'b1; statWrData = 32'hFFFF_FFDF;
    @(negedge clk);
    statWrEn = 1'b0; statWrData = '0;
    chk("R9 zero bit write no effect", txStat, 32'h20);
    repeat (5) @(negedge clk);
    chk("R9 sticky", txStat, 32'h20);
    clearDone();
    chk("R9 cleared by W1C", txStat, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    memRdData = '0;
    repeat (4) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testEnableOff();
    testSingle();
    testW1C();
    testMulti(1'b0);
    clearDone();
    testMulti(1'b1);
    clearDone();
    testWrap();
    clearDone();
    testExhaust();
    clearDone();
    testEmpty();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule